// File: doc/BRIEF.md
# Programmable Millisecond Tick Generator

The block emits a single-cycle pulse at a fixed interval measured in bus clock cycles. The interval is a 20-bit terminal count held in a software-visible 32-bit register. The default terminal count gives a 1 ms interval on a 100 MHz clock. A command-completion coalescing function uses the pulse as its time base.

The terminal count has its own power-on reset and is not disturbed by the global reset. While the coalescing function is enabled, the count is frozen and writes to it are dropped without notice. A cycle counter runs only while the enable is high. It starts again from zero each time the enable is raised.

Top module: `ms_tick_gen`

## Requirements
- R1: `rd_data_o[19:0]` returns the stored terminal count and `rd_data_o[31:20]` always reads 0, whatever value was written to those bits.
- R2: After `por_ni` is asserted, the terminal count reads 100000 (0x000186A0).
- R3: Asserting `rst_ni` clears the cycle counter but leaves the terminal count unchanged.
- R4: A write (`wr_en_i` high at a rising clock edge) while `coal_en_i` is low stores `wr_data_i[19:0]`, and the new value can be read from the next cycle on.
- R5: A write while `coal_en_i` is high is ignored, and the stored terminal count keeps its old value.
- R6: While `coal_en_i` is low, the counter is held at zero and `tick_o` stays low.
- R7: For a terminal count N of 2 or more, `tick_o` is high for one cycle in the Nth enabled cycle and then once every N cycles.
- R8: A terminal count of 0 or 1 makes `tick_o` high in every enabled cycle.
- R9: When `coal_en_i` rises again after a partial interval, counting restarts from zero, so the first tick comes N cycles after the rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| por_ni | input | 1 | Power-on reset, active low, asynchronous; resets everything |
| rst_ni | input | 1 | Global reset, active low, asynchronous; resets the counter only |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Register read data |
| coal_en_i | input | 1 | Coalescing enable; runs the counter and locks the register |
| tick_o | output | 1 | One-cycle interval pulse |

## Verification
A corrupted terminal count shows on `rd_data_o` in the cycle after the write or reset that caused it. It also moves every later tick. A counter that fails to clear or wrap shows as a tick arriving early or late against the expected cycle. That error is seen at the first tick after enable, which comes within N cycles. A lock that leaks shows in two ways: the readback value changes, and the tick spacing drifts from the old count for the rest of the enabled run.

// File: rtl/ms_tick_pkg.sv
package ms_tick_pkg;
  localparam int REG_W    = 32;
  localparam int PERIOD_W = 20;
  localparam logic [PERIOD_W-1:0] PERIOD_RST = 20'd100000;
endpackage

// File: rtl/tick_period_reg.sv
module tick_period_reg #(
  parameter int REG_W    = ms_tick_pkg::REG_W,
  parameter int PERIOD_W = ms_tick_pkg::PERIOD_W,
  parameter logic [PERIOD_W-1:0] RST_VAL = ms_tick_pkg::PERIOD_RST
) (
  input  logic                clk_i,
  input  logic                por_ni,
  input  logic                wr_en_i,
  input  logic [REG_W-1:0]    wr_data_i,
  input  logic                lock_i,
  output logic [PERIOD_W-1:0] period_o,
  output logic [REG_W-1:0]    rd_data_o
);
  localparam int RSV_W = REG_W - PERIOD_W;

  logic [PERIOD_W-1:0] period_q;

  // power-on domain only
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)                 period_q <= RST_VAL;
    else if (wr_en_i && !lock_i) period_q <= wr_data_i[PERIOD_W-1:0];
  end

  assign period_o  = period_q;
  assign rd_data_o = {{RSV_W{1'b0}}, period_q};

  assert_lock_R5: assert property (@(posedge clk_i) disable iff (!por_ni)
    (wr_en_i && lock_i) |=> $stable(period_q));

  assert_write_R4: assert property (@(posedge clk_i) disable iff (!por_ni)
    (wr_en_i && !lock_i) |=> (rd_data_o[PERIOD_W-1:0] == $past(wr_data_i[PERIOD_W-1:0])));

  assert_rsv_zero_R1: assert property (@(posedge clk_i) disable iff (!por_ni)
    rd_data_o[REG_W-1:PERIOD_W] == '0);
endmodule

// File: rtl/tick_cycle_counter.sv
module tick_cycle_counter #(
  parameter int CNT_W = ms_tick_pkg::PERIOD_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, last;
  logic             short_per, hit;

  assign last      = period_i - CNT_W'(1);
  assign short_per = period_i < CNT_W'(2);
  // >= guards against a count left above a newly shortened period
  assign hit       = short_per || (cnt_q >= last);

  always_comb begin
    if (!en_i)    cnt_d = '0;
    else if (hit) cnt_d = '0;
    else          cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign tick_o = en_i && hit;

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));

  assert_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0));

  assert_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_o) |=> (cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1))));

  assert_every_cycle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && short_per) |=> (cnt_q == '0));
endmodule

// File: rtl/ms_tick_gen.sv
module ms_tick_gen #(
  parameter int REG_W    = ms_tick_pkg::REG_W,
  parameter int PERIOD_W = ms_tick_pkg::PERIOD_W,
  parameter logic [PERIOD_W-1:0] RST_VAL = ms_tick_pkg::PERIOD_RST
) (
  input  logic             clk_i,
  input  logic             por_ni,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             coal_en_i,
  output logic             tick_o
);
  logic [PERIOD_W-1:0] period;
  logic                cnt_rst_n;

  assign cnt_rst_n = rst_ni & por_ni;

  tick_period_reg #(.REG_W(REG_W), .PERIOD_W(PERIOD_W), .RST_VAL(RST_VAL)) u_reg (
    .clk_i     (clk_i),
    .por_ni    (por_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .lock_i    (coal_en_i),
    .period_o  (period),
    .rd_data_o (rd_data_o)
  );

  tick_cycle_counter #(.CNT_W(PERIOD_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (cnt_rst_n),
    .en_i     (coal_en_i),
    .period_i (period),
    .tick_o   (tick_o)
  );

  assert_por_default_R2: assert property (@(posedge clk_i)
    $rose(por_ni) |-> (rd_data_o == {{(REG_W-PERIOD_W){1'b0}}, RST_VAL}));

  assert_idle_R6: assert property (@(posedge clk_i) disable iff (!por_ni)
    !coal_en_i |-> !tick_o);
endmodule

// File: tb/tb_ms_tick_gen.sv
module tb_ms_tick_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 20000;

  logic        clk = 1'b0;
  logic        por_n = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        tick;

  int checks = 0, fails = 0, cyc = 0;
  int exp_q[$];
  string cur_req = "R7";
  bit done = 1'b0;

  ms_tick_gen dut (
    .clk_i(clk), .por_ni(por_n), .rst_ni(rst_n), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .coal_en_i(en), .tick_o(tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (por_n && rst_n) begin
      automatic bit exp_t = (exp_q.size() > 0) && (exp_q[0] == cyc);
      if (exp_t || tick) begin
        checks++;
        if (tick !== exp_t) begin
          fails++;
          $display("FAIL %s: tick actual=%0b expected=%0b at cycle %0d", cur_req, tick, exp_t, cyc);
        end
      end
      if (exp_t) void'(exp_q.pop_front());
    end
  end

  task automatic reg_write(input logic [31:0] d);
    @(posedge clk); #1 wr_en = 1'b1; wr_data = d;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  // driver: enable for len cycles, push expected tick cycles
  task automatic run_ticks(input int n, input int len, input bit try_write, input string req);
    int start, step;
    cur_req = req;
    @(posedge clk); #1 en = 1'b1;
    if (try_write) begin wr_en = 1'b1; wr_data = 32'h0000_0055; end
    start = cyc;
    step  = (n <= 1) ? 1 : n;
    for (int c = start + step - 1; c < start + len; c += step) exp_q.push_back(c);
    @(posedge clk); #1 wr_en = 1'b0;
    repeat (len - 1) @(posedge clk);
    #1 en = 1'b0;
  endtask

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    chk("R2", rd_data, 32'h0001_86A0);
    chk("R6", {31'b0, tick}, 32'h0);

    reg_write(32'hFFF0_0ABC);
    chk("R1", rd_data, 32'h0000_0ABC);
    reg_write(32'h0000_0005);
    chk("R4", rd_data, 32'h0000_0005);

    run_ticks(5, 17, 1'b0, "R7");
    run_ticks(5, 12, 1'b1, "R5");
    @(negedge clk);
    chk("R5", rd_data, 32'h0000_0005);

    reg_write(32'h0000_0003);
    run_ticks(3, 10, 1'b0, "R7");

    reg_write(32'h0000_0001);
    run_ticks(1, 6, 1'b0, "R8");
    reg_write(32'h0000_0000);
    chk("R8", rd_data, 32'h0);
    run_ticks(0, 6, 1'b0, "R8");

    reg_write(32'h0000_0007);
    run_ticks(7, 4, 1'b0, "R9");
    run_ticks(7, 16, 1'b0, "R9");

    // idle stretch: no ticks expected
    cur_req = "R6";
    repeat (10) @(posedge clk);

    // global reset keeps period, clears counter
    reg_write(32'h0000_0004);
    @(posedge clk); #1 en = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b0; en = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R3", rd_data, 32'h0000_0004);
    run_ticks(4, 9, 1'b0, "R3");

    // power-on reset restores default
    @(posedge clk); #1 por_n = 1'b0;
    @(posedge clk); #1 por_n = 1'b1;
    @(negedge clk);
    chk("R2", rd_data, 32'h0001_86A0);

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule